// File: doc/BRIEF.md
# Fly-by DMA Command Strobe Sequencer

This block produces the four active-low bus command strobes for one fly-by DMA transfer. In a fly-by transfer, data moves straight between an I/O device and memory and is never held in a register on the way. The block drives only the strobes. A transfer toward memory pairs an I/O read with a memory write. A transfer out of memory pairs a memory read with an I/O write.

The sequencer runs on the DMA clock. A one-clock start pulse launches a transfer. On that edge the block captures the direction and a memory-read delay value, which is supplied by a configuration register outside the block.

- **Memory-write transfers** always use extended timing: the I/O read strobe falls one clock before the memory write strobe.
- **Memory-read transfers** hold the memory read strobe back by the programmed number of clocks, so that it lines up with the I/O write strobe. At the end, the I/O write strobe is released one clock ahead of the memory read strobe, so the device can capture data on that rising edge while memory still drives it.

Once every strobe has returned high, a one-clock done pulse marks the end of the transfer.

Top module: `dma_flyby_strobe`

## Requirements
- R1: During reset and directly after it, `ior_n`, `iow_n`, `memr_n` and `memw_n` are 1 and `done` is 0. An asserted reset in the middle of a transfer returns all strobes high.
- R2: A start with `mem_wr`=1 drives `ior_n` low in the clock after the start edge and `memw_n` low one clock after that. `iow_n` and `memr_n` stay high for the whole transfer, and the two strobe pairs are never low together.
- R3: In a memory-write transfer, `ior_n` and `memw_n` both return high in the same clock, 3 clocks after `memw_n` fell.
- R4: A start with `mem_wr`=0 drives `iow_n` low in the clock after the start edge and `memr_n` low `memr_dly` clocks after that. `ior_n` and `memw_n` stay high for the whole transfer.
- R5: With `memr_dly`=0, `memr_n` falls in the same clock as `iow_n`.
- R6: In a memory-read transfer, `iow_n` returns high 3 clocks after `memr_n` fell, and `memr_n` returns high one clock after `iow_n`. `memr_n` is low whenever `iow_n` rises.
- R7: `done` is high for exactly one clock, one clock after the last strobe returns high. All strobes are high while `done` is high.
- R8: A start that arrives while a transfer is in progress, including in the gap cycle and in the done cycle, is ignored. A start in the clock after the done pulse is accepted.
- R9: `mem_wr` and `memr_dly` are sampled only at an accepted start. Changing them later has no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DMA clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transfer launch pulse, sampled on the rising clock edge |
| mem_wr | input | 1 | 1: I/O-to-memory (I/O read + memory write); 0: memory-to-I/O (memory read + I/O write) |
| memr_dly | input | DLY_W | Memory-read strobe delay in clocks, from the configuration register |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| done | output | 1 | One-clock end-of-transfer pulse |

## Verification
Two events can fall in the same clock, and the bench provokes each one.

**Both read strobes falling together.** With a zero delay, the memory read strobe and the I/O write strobe drop in the same cycle. The bench runs that vector from its table and requires that the recorded fall cycles of both strobes are equal.

**A new start during the done pulse.** The bench raises a fresh start, with the opposite direction and a different delay, exactly in the done cycle and in the cycle before it. It then watches twenty further cycles for any second strobe fall, a wrong-pair strobe or a second done pulse. A separate back-to-back run places the next start one clock after the done pulse and requires that it launches at once.

// File: rtl/dma_flyby_strobe.sv
module dma_flyby_strobe #(
  parameter int DLY_W    = 4,
  parameter int ACT_CLKS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mem_wr,
  input  logic [DLY_W-1:0] memr_dly,
  output logic             ior_n,
  output logic             iow_n,
  output logic             memr_n,
  output logic             memw_n,
  output logic             done
);

  localparam int AW = $clog2(ACT_CLKS + 1);
  localparam int CW = (DLY_W > AW) ? DLY_W : AW;
  localparam logic [CW-1:0] ACT_LOAD = CW'(ACT_CLKS - 1);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_ACT, S_TAIL, S_POST, S_DONE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      wr_q   <= 1'b0;
      ior_n  <= 1'b1;
      iow_n  <= 1'b1;
      memr_n <= 1'b1;
      memw_n <= 1'b1;
      done   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          wr_q <= mem_wr;
          if (mem_wr) begin
            ior_n <= 1'b0;
            cnt   <= '0;
            st    <= S_LEAD;
          end else begin
            iow_n <= 1'b0;
            if (memr_dly == '0) begin
              memr_n <= 1'b0;
              cnt    <= ACT_LOAD;
              st     <= S_ACT;
            end else begin
              cnt <= CW'(memr_dly) - CW'(1);
              st  <= S_LEAD;
            end
          end
        end
        S_LEAD: if (cnt == '0) begin
          if (wr_q) memw_n <= 1'b0;
          else      memr_n <= 1'b0;
          cnt <= ACT_LOAD;
          st  <= S_ACT;
        end else begin
          cnt <= cnt - CW'(1);
        end
        S_ACT: if (cnt == '0) begin
          ior_n  <= 1'b1;
          memw_n <= 1'b1;
          iow_n  <= 1'b1;
          st     <= wr_q ? S_POST : S_TAIL;
        end else begin
          cnt <= cnt - CW'(1);
        end
        S_TAIL: begin
          memr_n <= 1'b1;
          st     <= S_POST;
        end
        S_POST: begin
          done <= 1'b1;
          st   <= S_DONE;
        end
        S_DONE: begin
          done <= 1'b0;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_flyby_strobe_chk.sv
module dma_flyby_strobe_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic ior_n,
  input logic iow_n,
  input logic memr_n,
  input logic memw_n,
  input logic done
);

  a_r2_pairs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !((!ior_n || !memw_n) && (!iow_n || !memr_n)));

  a_r2_ior_leads_memw: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(memw_n) |-> $past(!ior_n));

  a_r3_write_rise_together: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ior_n) |-> $rose(memw_n));

  a_r4_memr_under_iow: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(memr_n) |-> !iow_n);

  a_r6_iow_rises_under_memr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iow_n) |-> !memr_n);

  a_r7_done_strobes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ior_n && iow_n && memr_n && memw_n));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (!ior_n || !iow_n || !memr_n || !memw_n || done))
      |=> !($fell(ior_n) || $fell(iow_n)));

endmodule

bind dma_flyby_strobe dma_flyby_strobe_chk u_chk (.*);

// File: tb/sim_dma_flyby_strobe.sv
module sim_dma_flyby_strobe;
  localparam int PERIOD = 10;
  localparam int DW     = 4;
  localparam int NV     = 8;
  // {dir, dly, first_fall, second_fall, first_rise, second_rise, done, busy_at}
  localparam logic [31:0] VEC [NV] = '{
    {4'd1, 4'd3, 4'd1, 4'd2,  4'd5,  4'd5,  4'd6,  4'd0},
    {4'd0, 4'd0, 4'd1, 4'd1,  4'd4,  4'd5,  4'd6,  4'd0},
    {4'd0, 4'd1, 4'd1, 4'd2,  4'd5,  4'd6,  4'd7,  4'd0},
    {4'd0, 4'd4, 4'd1, 4'd5,  4'd8,  4'd9,  4'd10, 4'd0},
    {4'd0, 4'd9, 4'd1, 4'd10, 4'd13, 4'd14, 4'd15, 4'd0},
    {4'd1, 4'd0, 4'd1, 4'd2,  4'd5,  4'd5,  4'd6,  4'd3},
    {4'd0, 4'd2, 4'd1, 4'd3,  4'd6,  4'd7,  4'd8,  4'd8},
    {4'd1, 4'd5, 4'd1, 4'd2,  4'd5,  4'd5,  4'd6,  4'd5}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mem_wr = 1'b0;
  logic [DW-1:0] memr_dly = '0;
  logic ior_n, iow_n, memr_n, memw_n, done;

  always #(PERIOD/2) clk = ~clk;

  dma_flyby_strobe #(.DLY_W(DW), .ACT_CLKS(3)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_wr(mem_wr), .memr_dly(memr_dly),
    .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n), .memw_n(memw_n), .done(done));

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  int ff, sf, fr, sr, dn, dcnt, nfall, olow;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Caller stands at a negedge; start is raised at once and sampled on the next edge.
  task automatic run(bit d, int dly, int busy, int ncyc);
    logic p1 = 1'b1, p2 = 1'b1, s1, s2;
    ff = 0; sf = 0; fr = 0; sr = 0; dn = 0; dcnt = 0; nfall = 0; olow = 0;
    mem_wr = d; memr_dly = DW'(dly); start = 1'b1;
    for (int i = 1; i <= ncyc; i++) begin
      @(negedge clk);
      s1 = d ? ior_n : iow_n;
      s2 = d ? memw_n : memr_n;
      if (d ? (!iow_n || !memr_n) : (!ior_n || !memw_n)) olow = 1;
      if (!s1 && p1) begin nfall++; if (ff == 0) ff = i; end
      if (s1 && !p1 && fr == 0) fr = i;
      if (!s2 && p2 && sf == 0) sf = i;
      if (s2 && !p2 && sr == 0) sr = i;
      if (done) begin dcnt++; if (dn == 0) dn = i; end
      p1 = s1; p2 = s2;
      if (i == 1) start = 1'b0;
      if (busy != 0 && i == busy) begin start = 1'b1; mem_wr = !d; memr_dly = 4'd7; end
      if (busy != 0 && i == busy + 1) start = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ior_n", ior_n, 1);
    chk("R1 reset iow_n", iow_n, 1);
    chk("R1 reset memr_n", memr_n, 1);
    chk("R1 reset memw_n", memw_n, 1);
    chk("R1 reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      bit d;
      int dly, busy;
      d    = VEC[k][28];
      dly  = int'(VEC[k][27:24]);
      busy = int'(VEC[k][3:0]);
      run(d, dly, busy, 20);
      chk(d ? "R2 ior_n fall" : "R4 iow_n fall", ff, int'(VEC[k][23:20]));
      chk(d ? "R2 memw_n fall" : ((dly == 0) ? "R5 memr_n fall with iow_n" : "R4 memr_n fall"),
          sf, int'(VEC[k][19:16]));
      chk(d ? "R3 ior_n rise" : "R6 iow_n rise", fr, int'(VEC[k][15:12]));
      chk(d ? "R3 memw_n rise" : "R6 memr_n rise", sr, int'(VEC[k][11:8]));
      chk("R7 done cycle", dn, int'(VEC[k][7:4]));
      chk("R7 done width", dcnt, 1);
      chk((busy != 0) ? "R8 busy start single launch" : "R2 single launch", nfall, 1);
      chk((busy != 0) ? "R9 direction held" : (d ? "R2 read pair idle" : "R4 write pair idle"),
          olow, 0);
    end

    run(1'b1, 0, 0, 7);
    chk("R7 back-to-back first done", dn, 6);
    run(1'b0, 0, 0, 20);
    chk("R8 start after done accepted", ff, 1);
    chk("R8 start after done memr_n", sf, 1);

    run(1'b0, 5, 0, 3);
    chk("R1 mid-transfer iow_n low", iow_n, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-transfer reset iow_n", iow_n, 1);
    chk("R1 mid-transfer reset memr_n", memr_n, 1);
    rst_n = 1'b1;
    @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 50000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule